// File: doc/BRIEF.md
# Long-Write Termination Interrupt Controller

This block watches over a multi-cycle write to non-volatile memory. A reset event, or any interrupt source that has both its enable and its flag set, ends the write early. The global enables and the per-source priority bits never decide *whether* the write stops. They only decide where execution goes next: the high vector, the low vector, or the next instruction in line.

The controller also requests a wake from sleep when an enabled source flags. It keeps a sticky status bit so that software can tell that the last write was cut short and must be checked and reprogrammed.

The write timing itself sits outside the block. A busy level (`wr_busy`) and a completion pulse (`wr_done`) stand in for it. The block only reads the interrupt flags and never clears them, so a flag stays set until software clears it.

Every decision is registered. An input pattern sampled on one rising edge shows on the outputs after that same edge, so the outputs lag the sampled inputs by one clock.

Top module: `lwt_ctrl`

## Requirements
- R1: While `rst_n` is low, all outputs are 0. This includes `wr_err`.
- R2: A write is live while `wr_busy` is 1 and no abort has yet been issued for it. In a live write, a source with `irq_en[i]=1` and `irq_flag[i]=1` makes `wr_abort` pulse one clock later. The values of `irq_prio`, `gie_high` and `gie_low` have no effect on this.
- R3: `warm_rst=1` during a live write makes `wr_abort` pulse one clock later, with `vec_high`, `vec_low` and `resume_next` all 0. The reset takes precedence over any pending interrupt.
- R4: A source with `irq_en[i]=0` never aborts the write and never raises `wake_req`, whatever its flag does, even while `in_sleep=1`.
- R5: After an abort, no further abort is issued until `wr_busy` has been 0 for at least one clock.
- R6: On an interrupt abort, if any pending source has `irq_prio[i]=1` (high) and `gie_high=1`, then `vec_high` pulses together with `wr_abort`.
- R7: On an interrupt abort with no high-priority source pending, `vec_low` pulses when `gie_high=1` and `gie_low=1`. If high and low sources pend in the same cycle, the high vector wins.
- R8: An interrupt abort that matches neither R6 nor R7 pulses `resume_next`. At most one of `vec_high`, `vec_low` and `resume_next` is ever 1, and only alongside `wr_abort`.
- R9: While `in_sleep=1` and any enabled source is flagged, `wake_req` is 1 one clock later. This does not depend on `wr_busy`.
- R10: `wr_err` becomes 1 together with any `wr_abort`. It returns to 0 the clock after `sw_clr_err=1`, or after `wr_done=1` during a live write. If setting and clearing happen in the same cycle, the set wins.
- R11: With `wr_busy=0`, no abort, vector or resume output is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_busy | input | 1 | Long write in progress |
| wr_done | input | 1 | Write finished normally (pulse) |
| warm_rst | input | 1 | Synchronous reset event that kills the write |
| in_sleep | input | 1 | Core is in sleep |
| irq_flag | input | NSRC | Per-source interrupt flags |
| irq_en | input | NSRC | Per-source interrupt enables |
| irq_prio | input | NSRC | Per-source priority, 1 = high |
| gie_high | input | 1 | Global enable for high priority |
| gie_low | input | 1 | Global enable for low priority |
| sw_clr_err | input | 1 | Software clear of the status bit |
| wr_abort | output | 1 | Write abort strobe |
| resume_next | output | 1 | Continue at the next instruction |
| vec_high | output | 1 | Branch to the high priority vector |
| vec_low | output | 1 | Branch to the low priority vector |
| wake_req | output | 1 | Wake from sleep |
| wr_err | output | 1 | Sticky "write terminated unexpectedly" status |

## Verification
The properties assume that every input except `rst_n` is synchronous to `clk` and stable around the rising edge. They also assume that `rst_n` is the only asynchronous input. The stimulus changes every input on the falling edge only. Directed phases pair each decision with the inputs that must not change it: priority bits and global enables for the abort decision, and disabled flags while the core sleeps. A long unconstrained random phase then lets `wr_done`, `sw_clr_err` and `warm_rst` collide with aborts. Any such collision is legal, because the bench reference model defines the outcome for every mix of inputs.

// File: rtl/lwt_pkg.sv
package lwt_pkg;

  typedef enum logic [1:0] {
    RT_NONE   = 2'd0,
    RT_NEXT   = 2'd1,
    RT_VEC_HI = 2'd2,
    RT_VEC_LO = 2'd3
  } route_e;

  typedef struct packed {
    logic   abort;
    route_e route;
  } decision_t;

endpackage

// File: rtl/lwt_src_reduce.sv
module lwt_src_reduce #(
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0] flag,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] prio,
  output logic            any_pend,
  output logic            hi_pend,
  output logic            lo_pend
);
  logic [NSRC-1:0] pend_v;
  logic [NSRC-1:0] hi_v;
  logic [NSRC-1:0] lo_v;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign pend_v[g] = flag[g] & en[g];
    assign hi_v[g]   = pend_v[g] & prio[g];
    assign lo_v[g]   = pend_v[g] & ~prio[g];
  end

  assign any_pend = |pend_v;
  assign hi_pend  = |hi_v;
  assign lo_pend  = |lo_v;
endmodule

// File: rtl/lwt_route.sv
module lwt_route
  import lwt_pkg::*;
(
  input  logic      live,
  input  logic      warm_rst,
  input  logic      any_pend,
  input  logic      hi_pend,
  input  logic      lo_pend,
  input  logic      gie_high,
  input  logic      gie_low,
  output decision_t dec
);
  always_comb begin
    dec.abort = 1'b0;
    dec.route = RT_NONE;
    if (live) begin
      if (warm_rst) begin
        dec.abort = 1'b1;
      end else if (any_pend) begin
        dec.abort = 1'b1;
        if (hi_pend && gie_high)                   dec.route = RT_VEC_HI;
        else if (lo_pend && gie_high && gie_low)   dec.route = RT_VEC_LO;
        else                                       dec.route = RT_NEXT;
      end
    end
  end
endmodule

// File: rtl/lwt_status.sv
module lwt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_busy,
  input  logic wr_done,
  input  logic sw_clr_err,
  input  logic abort_now,
  output logic live,
  output logic wr_err
);
  logic kill_q;

  assign live = wr_busy & ~kill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          kill_q <= 1'b0;
    else if (!wr_busy)   kill_q <= 1'b0;
    else if (abort_now)  kill_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               wr_err <= 1'b0;
    else if (abort_now)                       wr_err <= 1'b1;
    else if (sw_clr_err || (wr_done && live)) wr_err <= 1'b0;
  end
endmodule

// File: rtl/lwt_ctrl.sv
module lwt_ctrl
  import lwt_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_busy,
  input  logic            wr_done,
  input  logic            warm_rst,
  input  logic            in_sleep,
  input  logic [NSRC-1:0] irq_flag,
  input  logic [NSRC-1:0] irq_en,
  input  logic [NSRC-1:0] irq_prio,
  input  logic            gie_high,
  input  logic            gie_low,
  input  logic            sw_clr_err,
  output logic            wr_abort,
  output logic            resume_next,
  output logic            vec_high,
  output logic            vec_low,
  output logic            wake_req,
  output logic            wr_err
);
  logic      any_pend, hi_pend, lo_pend;
  logic      write_live;
  decision_t dec;

  lwt_src_reduce #(.NSRC(NSRC)) u_reduce (
    .flag     (irq_flag),
    .en       (irq_en),
    .prio     (irq_prio),
    .any_pend (any_pend),
    .hi_pend  (hi_pend),
    .lo_pend  (lo_pend)
  );

  lwt_route u_route (
    .live     (write_live),
    .warm_rst (warm_rst),
    .any_pend (any_pend),
    .hi_pend  (hi_pend),
    .lo_pend  (lo_pend),
    .gie_high (gie_high),
    .gie_low  (gie_low),
    .dec      (dec)
  );

  lwt_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_busy    (wr_busy),
    .wr_done    (wr_done),
    .sw_clr_err (sw_clr_err),
    .abort_now  (dec.abort),
    .live       (write_live),
    .wr_err     (wr_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_abort    <= 1'b0;
      resume_next <= 1'b0;
      vec_high    <= 1'b0;
      vec_low     <= 1'b0;
      wake_req    <= 1'b0;
    end else begin
      wr_abort    <= dec.abort;
      resume_next <= (dec.route == RT_NEXT);
      vec_high    <= (dec.route == RT_VEC_HI);
      vec_low     <= (dec.route == RT_VEC_LO);
      wake_req    <= in_sleep & any_pend;
    end
  end
endmodule

// File: rtl/lwt_ctrl_chk.sv
module lwt_ctrl_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_busy,
  input logic            warm_rst,
  input logic            in_sleep,
  input logic [NSRC-1:0] irq_flag,
  input logic [NSRC-1:0] irq_en,
  input logic            write_live,
  input logic            wr_abort,
  input logic            resume_next,
  input logic            vec_high,
  input logic            vec_low,
  input logic            wake_req,
  input logic            wr_err
);
  p_enabled_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (write_live && ((irq_flag & irq_en) != '0)) |=> wr_abort);

  p_reset_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (write_live && warm_rst) |=> (wr_abort && !vec_high && !vec_low && !resume_next));

  p_disabled_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!warm_rst && ((irq_flag & irq_en) == '0)) |=> !wr_abort);

  p_single_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |=> !wr_abort);

  p_route_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vec_high, vec_low, resume_next}));

  p_route_with_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_high || vec_low || resume_next) |-> wr_abort);

  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && ((irq_flag & irq_en) != '0)) |=> wake_req);

  p_err_on_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |-> wr_err);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_busy |=> !wr_abort);
endmodule

bind lwt_ctrl lwt_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_busy     (wr_busy),
  .warm_rst    (warm_rst),
  .in_sleep    (in_sleep),
  .irq_flag    (irq_flag),
  .irq_en      (irq_en),
  .write_live  (write_live),
  .wr_abort    (wr_abort),
  .resume_next (resume_next),
  .vec_high    (vec_high),
  .vec_low     (vec_low),
  .wake_req    (wake_req),
  .wr_err      (wr_err)
);

// File: tb/tb_lwt_ctrl.sv
`timescale 1ns/100ps
module tb_lwt_ctrl;
  localparam int NSRC = 8;

  logic clk = 1'b0;
  logic rst_n, wr_busy, wr_done, warm_rst, in_sleep, gie_high, gie_low, sw_clr_err;
  logic [NSRC-1:0] irq_flag, irq_en, irq_prio;
  logic wr_abort, resume_next, vec_high, vec_low, wake_req, wr_err;

  always #2.5 clk = ~clk;

  lwt_ctrl #(.NSRC(NSRC)) dut (.*);

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done_flag = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_kill, m_err;
  bit e_abort, e_next, e_hi, e_lo, e_wake;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_kill = 0; m_err = 0;
      e_abort = 0; e_next = 0; e_hi = 0; e_lo = 0; e_wake = 0;
    end else begin
      bit live, hp, lp, ap, ab;
      live = wr_busy && !m_kill;
      hp = 0; lp = 0;
      for (int i = 0; i < NSRC; i++) begin
        if (irq_flag[i] && irq_en[i]) begin
          if (irq_prio[i]) hp = 1; else lp = 1;
        end
      end
      ap = hp || lp;
      ab = live && (warm_rst || ap);
      e_abort = ab;
      e_hi = 0; e_lo = 0; e_next = 0;
      if (ab && !warm_rst) begin
        if (hp && gie_high)                 e_hi = 1;
        else if (lp && gie_high && gie_low) e_lo = 1;
        else                                e_next = 1;
      end
      e_wake = in_sleep && ap;
      if (ab) m_err = 1;
      else if (sw_clr_err || (wr_done && live)) m_err = 0;
      if (!wr_busy) m_kill = 0;
      else if (ab)  m_kill = 1;
    end
  end

  task automatic chk1(string name, logic act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", cur_req, name, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk1("wr_abort", wr_abort, e_abort);
    chk1("resume_next", resume_next, e_next);
    chk1("vec_high", vec_high, e_hi);
    chk1("vec_low", vec_low, e_lo);
    chk1("wake_req", wake_req, e_wake);
    chk1("wr_err", wr_err, m_err);
  endtask

  // advance one edge, then compare away from the edge; return at falling edge
  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      compare_all();
      @(negedge clk);
    end
  endtask

  task automatic idle();
    wr_busy = 0; wr_done = 0; warm_rst = 0; in_sleep = 0;
    gie_high = 0; gie_low = 0; sw_clr_err = 0;
    irq_flag = '0; irq_en = '0; irq_prio = '0;
  endtask

  task automatic new_write();
    irq_flag = '0; warm_rst = 0; wr_busy = 0; tick();
    wr_busy = 1; tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    // R1: outputs held at zero in reset, even with a flagged enabled source
    wr_busy = 1; irq_en = 8'h01; irq_flag = 8'h01;
    repeat (3) begin
      @(negedge clk);
      cur_req = "R1"; compare_all();
    end
    idle();
    rst_n = 1;
    tick(2);

    // R2: enabled flag aborts regardless of prio and global enables
    cur_req = "R2";
    new_write();
    irq_en = 8'h04; irq_prio = 8'h04; gie_high = 0; gie_low = 0;
    irq_flag = 8'h04;
    tick(2);

    // R6: high source with gie_high
    cur_req = "R6";
    new_write();
    gie_high = 1; irq_en = 8'h10; irq_prio = 8'h10; irq_flag = 8'h10;
    tick(2);

    // R7: low source with both enables, then both levels at once
    cur_req = "R7";
    new_write();
    gie_high = 1; gie_low = 1; irq_en = 8'h03; irq_prio = 8'h02; irq_flag = 8'h01;
    tick(2);
    new_write();
    irq_flag = 8'h03;
    tick(2);

    // R8: low source with gie_low clear, high source with gie_high clear
    cur_req = "R8";
    new_write();
    gie_high = 1; gie_low = 0; irq_en = 8'h01; irq_prio = 8'h00; irq_flag = 8'h01;
    tick(2);
    new_write();
    gie_high = 0; gie_low = 1; irq_en = 8'h80; irq_prio = 8'h80; irq_flag = 8'h80;
    tick(2);

    // R4: disabled source flagged in sleep
    cur_req = "R4";
    new_write();
    in_sleep = 1; irq_en = 8'h00; irq_flag = 8'hFF;
    tick(4);

    // R9: sleeping, enabled source, flag rises later
    cur_req = "R9";
    irq_flag = '0; in_sleep = 1; irq_en = 8'h20;
    new_write();
    tick(3);
    irq_flag = 8'h20;
    tick(3);
    in_sleep = 0;

    // R3: warm reset with a pending interrupt too
    cur_req = "R3";
    new_write();
    warm_rst = 1; gie_high = 1; irq_en = 8'h01; irq_prio = 8'h01; irq_flag = 8'h01;
    tick(2);
    warm_rst = 0;

    // R5: cause held many cycles, only one abort
    cur_req = "R5";
    new_write();
    irq_en = 8'h08; irq_flag = 8'h08;
    tick(6);

    // R10: clear by software, clear by completion, set beats clear
    cur_req = "R10";
    irq_flag = '0; wr_busy = 0; tick();
    sw_clr_err = 1; tick(); sw_clr_err = 0; tick();
    new_write(); irq_flag = 8'h08; tick(); irq_flag = '0;
    wr_busy = 0; tick(); wr_busy = 1; tick(3);
    wr_done = 1; tick(); wr_done = 0; wr_busy = 0; tick();
    new_write(); irq_flag = 8'h08; sw_clr_err = 1; wr_done = 1; tick();
    irq_flag = '0; sw_clr_err = 0; wr_done = 0; tick(2);

    // R11: no write in progress
    cur_req = "R11";
    wr_busy = 0; irq_en = 8'hFF; irq_flag = 8'hFF; gie_high = 1; gie_low = 1; warm_rst = 1;
    tick(4);
    idle(); tick();

    // mixed random traffic, compared every clock
    cur_req = "R2";
    for (int c = 0; c < 4000; c++) begin
      wr_busy    = ($urandom_range(0, 7) != 0);
      wr_done    = ($urandom_range(0, 15) == 0);
      warm_rst   = ($urandom_range(0, 31) == 0);
      in_sleep   = $urandom_range(0, 1);
      sw_clr_err = ($urandom_range(0, 15) == 0);
      gie_high   = $urandom_range(0, 1);
      gie_low    = $urandom_range(0, 1);
      irq_en     = NSRC'($urandom);
      irq_prio   = NSRC'($urandom);
      irq_flag   = ($urandom_range(0, 3) == 0) ? NSRC'($urandom) : '0;
      tick();
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule